// File: doc/BRIEF.md
# Audio DAC Control Register Unit

This unit holds the configuration of one audio DAC path: two power-down controls, the sample-rate speed mode, the serial interface format, the mute request, de-emphasis and master/slave select. Software reads and writes it over a flat register bus with an address, a write strobe, write data and combinational read data. The unit turns the settings into plain control outputs: a device low-power flag, a reset for the DAC pair, a speed-mode code, a format code, an active-low mute indicator and a sticky flag for a rejected speed code.

A small power sequencer owns the low-power and DAC-reset outputs. Its states are `PS_SLEEP` (device powered down), `PS_HOLD` (device awake, DAC pair held in reset) and `PS_RUN` (DAC pair released). The sequencer moves once per clock from the power register as it stood before that edge. `PS_SLEEP` goes to `PS_HOLD` when the device power-down bit is clear and the DAC power-down bit is set. It goes to `PS_RUN` when both are clear. Any state returns to `PS_SLEEP` when the device power-down bit is set. `PS_HOLD` goes to `PS_RUN` when the DAC bit clears, and `PS_RUN` goes back to `PS_HOLD` when it is set. The register file never changes because of the power state, so settings survive power-down. Writes are taken in every state, so software can configure the unit before it wakes the device.

Register map (byte data):
- Address 0 (power): bit 0 device power-down, which resets to 1. Bit 1 DAC power-down, which resets to 0. The other bits read as 0.
- Address 1 (DAC control): bits 7:6 speed, bits 5:4 format, bit 3 reserved, bit 2 mute, bit 1 de-emphasis, bit 0 master/slave. The whole register resets to 0x00.
- Address 2 (status): bit 0 is the speed error flag. Writing 1 to it clears the flag.

Speed codes are 00 single (4–50 kHz), 01 double (50–100 kHz), 10 quad (100–200 kHz) and 11 reserved.

Top module: `dac_ctrl_unit`

## Requirements
- R1: After reset, the power register reads 0x01, the DAC control register reads 0x00 and the status register reads 0x00. `lowpower_o`=1, `dac_rst_o`=1, `speed_o`=00, `fmt_o`=00, `mute_n_o`=1 and `spd_err_o`=0.
- R2: `lowpower_o` equals the device power-down bit one clock after that bit is written. While `lowpower_o` is 1, `dac_rst_o` is 1.
- R3: Writes to every register take effect while the device is powered down. Setting device power-down changes no stored register value.
- R4: With the device awake, `dac_rst_o` equals the DAC power-down bit (address 0, bit 1) one clock after that bit is written.
- R5: `speed_o` shows DAC control bits 7:6 and `fmt_o` shows bits 5:4 in the cycle after the write. The register reads back bits 7:4 and 2:0 as written.
- R6: A DAC control write with bits 7:6 = 11 keeps the previous speed code, sets `spd_err_o` and still stores the other fields of that write.
- R7: `spd_err_o` stays 1 until a status write with bit 0 = 1 clears it. A status write with bit 0 = 0 leaves it unchanged.
- R8: DAC control bit 3 always reads back as 0.
- R9: `mute_n_o` is the inverse of DAC control bit 2 in the cycle after the write, in every power state.
- R10: Reads of addresses other than 0, 1 and 2 return 0x00. Writes to those addresses change no output and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| lowpower_o | output | 1 | Device low-power flag |
| dac_rst_o | output | 1 | Reset to the DAC pair, active high |
| speed_o | output | 2 | Active speed-mode code |
| fmt_o | output | 2 | Serial interface format code |
| mute_n_o | output | 1 | Mute indicator, active low |
| spd_err_o | output | 1 | Sticky reserved-speed-code flag |

## Verification
A wrong sequencer state shows up at `lowpower_o` or `dac_rst_o` one clock after the power write that should have moved it. It does not wait for a later event. A corrupted register field or a failed reserved-code filter shows up at once on `reg_rdata`, and on `speed_o`, `fmt_o` or `mute_n_o` one clock after the write. The bench therefore compares every output and the read data of the current address in every cycle, against a model driven only by the register map. A fault is reported in the first cycle after it appears.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

    typedef enum logic [1:0] {
        PS_SLEEP = 2'd0,
        PS_HOLD  = 2'd1,
        PS_RUN   = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic [1:0] speed;
        logic [1:0] fmt;
        logic       mute;
        logic       deemph;
        logic       msel;
    } dac_cfg_t;

    localparam logic [1:0] SPEED_RSVD = 2'b11;
    localparam dac_cfg_t   CFG_RESET  = '0;

endpackage

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
    import dac_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int PWR_ADDR  = 0,
    parameter int CTRL_ADDR = 1,
    parameter int STAT_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              dev_pd,
    output logic              dac_pd,
    output dac_cfg_t          cfg,
    output logic              spd_err
);
    localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(PWR_ADDR);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    logic     wr_pwr, wr_ctrl, wr_stat, rsvd_hit;
    dac_cfg_t cfg_next;

    assign wr_pwr   = we && (addr == A_PWR);
    assign wr_ctrl  = we && (addr == A_CTRL);
    assign wr_stat  = we && (addr == A_STAT);
    assign rsvd_hit = (wdata[7:6] == SPEED_RSVD);

    // Reserved speed code is filtered here; the other fields pass through.
    always_comb begin
        cfg_next.speed  = rsvd_hit ? cfg.speed : wdata[7:6];
        cfg_next.fmt    = wdata[5:4];
        cfg_next.mute   = wdata[2];
        cfg_next.deemph = wdata[1];
        cfg_next.msel   = wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_pd <= 1'b1;
            dac_pd <= 1'b0;
        end else if (wr_pwr) begin
            dev_pd <= wdata[0];
            dac_pd <= wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
        end else if (wr_ctrl) begin
            cfg <= cfg_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spd_err <= 1'b0;
        end else if (wr_ctrl && rsvd_hit) begin
            spd_err <= 1'b1;
        end else if (wr_stat && wdata[0]) begin
            spd_err <= 1'b0;
        end
    end
endmodule

// File: rtl/dac_ctrl_rdmux.sv
module dac_ctrl_rdmux
    import dac_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int PWR_ADDR  = 0,
    parameter int CTRL_ADDR = 1,
    parameter int STAT_ADDR = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              dev_pd,
    input  logic              dac_pd,
    input  dac_cfg_t          cfg,
    input  logic              spd_err,
    output logic [7:0]        rdata
);
    localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(PWR_ADDR);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    always_comb begin
        rdata = 8'h00;
        if (addr == A_PWR) begin
            rdata = {6'b0, dac_pd, dev_pd};
        end else if (addr == A_CTRL) begin
            rdata = {cfg.speed, cfg.fmt, 1'b0, cfg.mute, cfg.deemph, cfg.msel};
        end else if (addr == A_STAT) begin
            rdata = {7'b0, spd_err};
        end
    end
endmodule

// File: rtl/dac_ctrl_pwr_fsm.sv
module dac_ctrl_pwr_fsm
    import dac_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dev_pd,
    input  logic dac_pd,
    output logic lowpower,
    output logic dac_rst
);
    pwr_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PS_SLEEP;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PS_SLEEP: begin
                if (!dev_pd) state_nx = dac_pd ? PS_HOLD : PS_RUN;
            end
            PS_HOLD: begin
                if (dev_pd)       state_nx = PS_SLEEP;
                else if (!dac_pd) state_nx = PS_RUN;
            end
            PS_RUN: begin
                if (dev_pd)      state_nx = PS_SLEEP;
                else if (dac_pd) state_nx = PS_HOLD;
            end
            default: state_nx = PS_SLEEP;
        endcase
    end

    always_comb begin
        lowpower = 1'b1;
        dac_rst  = 1'b1;
        unique case (state)
            PS_SLEEP: begin lowpower = 1'b1; dac_rst = 1'b1; end
            PS_HOLD:  begin lowpower = 1'b0; dac_rst = 1'b1; end
            PS_RUN:   begin lowpower = 1'b0; dac_rst = 1'b0; end
            default:  begin lowpower = 1'b1; dac_rst = 1'b1; end
        endcase
    end
endmodule

// File: rtl/dac_ctrl_unit.sv
module dac_ctrl_unit
    import dac_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int PWR_ADDR  = 0,
    parameter int CTRL_ADDR = 1,
    parameter int STAT_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              lowpower_o,
    output logic              dac_rst_o,
    output logic [1:0]        speed_o,
    output logic [1:0]        fmt_o,
    output logic              mute_n_o,
    output logic              spd_err_o
);
    logic     dev_pd, dac_pd, spd_err;
    dac_cfg_t cfg;

    dac_ctrl_regs #(
        .ADDR_W(ADDR_W), .PWR_ADDR(PWR_ADDR),
        .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .dev_pd(dev_pd), .dac_pd(dac_pd),
        .cfg(cfg), .spd_err(spd_err)
    );

    dac_ctrl_rdmux #(
        .ADDR_W(ADDR_W), .PWR_ADDR(PWR_ADDR),
        .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
    ) u_rdmux (
        .addr(reg_addr), .dev_pd(dev_pd), .dac_pd(dac_pd),
        .cfg(cfg), .spd_err(spd_err), .rdata(reg_rdata)
    );

    dac_ctrl_pwr_fsm u_pwr (
        .clk(clk), .rst_n(rst_n), .dev_pd(dev_pd), .dac_pd(dac_pd),
        .lowpower(lowpower_o), .dac_rst(dac_rst_o)
    );

    assign speed_o   = cfg.speed;
    assign fmt_o     = cfg.fmt;
    assign mute_n_o  = ~cfg.mute;
    assign spd_err_o = spd_err;
endmodule

// File: rtl/dac_ctrl_unit_chk.sv
module dac_ctrl_unit_chk #(
    parameter int ADDR_W    = 4,
    parameter int PWR_ADDR  = 0,
    parameter int CTRL_ADDR = 1,
    parameter int STAT_ADDR = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [1:0]        wr_spd,
    input logic              wr_mute,
    input logic              wr_bit0,
    input logic              rd_zero,
    input logic              rd_bit3,
    input logic              lowpower_o,
    input logic              dac_rst_o,
    input logic [1:0]        speed_o,
    input logic [1:0]        fmt_o,
    input logic              mute_n_o,
    input logic              spd_err_o
);
    localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(PWR_ADDR);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    logic mapped;
    assign mapped = (reg_addr == A_PWR) || (reg_addr == A_CTRL) || (reg_addr == A_STAT);

    a_r2_sleep_holds_dac: assert property (@(posedge clk) disable iff (!rst_n)
        lowpower_o |-> dac_rst_o);

    a_r3_pd_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (lowpower_o && !reg_we) |=> ($stable(speed_o) && $stable(fmt_o) && $stable(mute_n_o)));

    a_r6_rsvd_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_CTRL && wr_spd == 2'b11) |=> (spd_err_o && $stable(speed_o)));

    a_r6_speed_valid: assert property (@(posedge clk) disable iff (!rst_n)
        speed_o != 2'b11);

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (spd_err_o && !(reg_we && reg_addr == A_STAT && wr_bit0)) |=> spd_err_o);

    a_r8_bit3_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CTRL) |-> !rd_bit3);

    a_r9_mute_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_CTRL) |=> (mute_n_o == !$past(wr_mute)));

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> rd_zero);
endmodule

bind dac_ctrl_unit dac_ctrl_unit_chk #(
    .ADDR_W(ADDR_W), .PWR_ADDR(PWR_ADDR),
    .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .wr_spd(reg_wdata[7:6]), .wr_mute(reg_wdata[2]), .wr_bit0(reg_wdata[0]),
    .rd_zero(reg_rdata == 8'h00), .rd_bit3(reg_rdata[3]),
    .lowpower_o(lowpower_o), .dac_rst_o(dac_rst_o), .speed_o(speed_o),
    .fmt_o(fmt_o), .mute_n_o(mute_n_o), .spd_err_o(spd_err_o)
);

// File: tb/dac_ctrl_unit_bench.sv
module dac_ctrl_unit_bench;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [7:0]        reg_wdata = 8'h00;
    logic [7:0]        reg_rdata;
    logic              lowpower_o, dac_rst_o, mute_n_o, spd_err_o;
    logic [1:0]        speed_o, fmt_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dac_ctrl_unit #(.ADDR_W(ADDR_W)) u_dac_ctrl_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lowpower_o(lowpower_o),
        .dac_rst_o(dac_rst_o), .speed_o(speed_o), .fmt_o(fmt_o),
        .mute_n_o(mute_n_o), .spd_err_o(spd_err_o)
    );

    // Model built from the register map in the requirements.
    logic [1:0] m_pwr;   // {dac_pd, dev_pd}
    logic [7:0] m_ctrl;
    logic       m_err, m_lp, m_rst;

    function automatic logic [7:0] ctrl_after(input logic [7:0] old, input logic [7:0] wd);
        logic [7:0] v;
        v = wd & 8'hF7;                         // R8: bit 3 kept at 0
        if (wd[7:6] == 2'b11) v[7:6] = old[7:6]; // R6: reserved speed refused
        return v;
    endfunction

    function automatic logic [7:0] readback(input logic [ADDR_W-1:0] a);
        case (a)
            4'd0:    return {6'b0, m_pwr};
            4'd1:    return m_ctrl;
            4'd2:    return {7'b0, m_err};
            default: return 8'h00;              // R10
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pwr <= 2'b01; m_ctrl <= 8'h00; m_err <= 1'b0;
            m_lp <= 1'b1; m_rst <= 1'b1;
        end else begin
            m_lp  <= m_pwr[0];
            m_rst <= m_pwr[0] | m_pwr[1];
            if (reg_we) begin
                case (reg_addr)
                    4'd0: m_pwr <= reg_wdata[1:0];
                    4'd1: begin
                        m_ctrl <= ctrl_after(m_ctrl, reg_wdata);
                        if (reg_wdata[7:6] == 2'b11) m_err <= 1'b1;
                    end
                    4'd2: if (reg_wdata[0]) m_err <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        chk(req, "lowpower_o", {7'b0, lowpower_o}, {7'b0, m_lp});
        chk(req, "dac_rst_o",  {7'b0, dac_rst_o},  {7'b0, m_rst});
        chk(req, "speed_o",    {6'b0, speed_o},    {6'b0, m_ctrl[7:6]});
        chk(req, "fmt_o",      {6'b0, fmt_o},      {6'b0, m_ctrl[5:4]});
        chk(req, "mute_n_o",   {7'b0, mute_n_o},   {7'b0, ~m_ctrl[2]});
        chk(req, "spd_err_o",  {7'b0, spd_err_o},  {7'b0, m_err});
    endtask

    // Check the state left by the last edge, then present the next access.
    task automatic step(input string req, input logic we, input logic [ADDR_W-1:0] a, input logic [7:0] wd);
        @(negedge clk);
        check_outs(req);
        reg_we = we; reg_addr = a; reg_wdata = wd;
        #1;
        chk(req, "reg_rdata", reg_rdata, readback(a));
    endtask

    initial begin
        void'($urandom(32'h0DAC_5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R1", 1'b0, 4'd0, 8'h00);
        chk("R1", "power reset", reg_rdata, 8'h01);
        step("R1", 1'b0, 4'd1, 8'h00);
        chk("R1", "ctrl reset", reg_rdata, 8'h00);
        // Configure while powered down; reserved speed and bit 3 in one write.
        step("R3", 1'b1, 4'd1, 8'hFF);
        step("R6", 1'b0, 4'd1, 8'h00);
        chk("R6", "ctrl after reserved", reg_rdata, 8'h37);
        chk("R8", "bit 3", {7'b0, reg_rdata[3]}, 8'h00);
        step("R7", 1'b1, 4'd2, 8'h00);
        step("R7", 1'b1, 4'd2, 8'h01);
        step("R7", 1'b1, 4'd1, 8'h84);
        step("R9", 1'b0, 4'd1, 8'h00);
        chk("R9", "mute pin in power-down", {7'b0, mute_n_o}, 8'h00);
        chk("R5", "quad speed", {6'b0, speed_o}, 8'h02);
        step("R2", 1'b1, 4'd0, 8'h00);
        step("R2", 1'b0, 4'd0, 8'h00);
        step("R2", 1'b0, 4'd0, 8'h00);
        chk("R2", "awake", {6'b0, lowpower_o, dac_rst_o}, 8'h00);
        step("R4", 1'b1, 4'd0, 8'h02);
        step("R4", 1'b0, 4'd0, 8'h00);
        step("R4", 1'b0, 4'd0, 8'h00);
        chk("R4", "hold", {6'b0, lowpower_o, dac_rst_o}, 8'h01);
        step("R5", 1'b1, 4'd1, 8'h5A);
        step("R3", 1'b1, 4'd0, 8'h01);
        step("R3", 1'b0, 4'd1, 8'h00);
        step("R3", 1'b0, 4'd1, 8'h00);
        chk("R3", "ctrl kept in power-down", reg_rdata, 8'h52);
        step("R10", 1'b1, 4'd5, 8'hFF);
        step("R10", 1'b1, 4'd15, 8'hFF);
        step("R10", 1'b0, 4'd1, 8'h00);
        chk("R10", "ctrl after unmapped writes", reg_rdata, 8'h52);
        for (int i = 0; i < 600; i++) begin
            logic [ADDR_W-1:0] a;
            logic [7:0]        wd;
            a  = ADDR_W'($urandom_range(0, 5));
            wd = 8'($urandom);
            if (a == 4'd0 && ($urandom_range(0, 3) != 0)) wd[0] = 1'b0;
            step("R5", 1'($urandom_range(0, 1)), a, wd);
        end
        step("R9", 1'b0, 4'd0, 8'h00);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule